// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the per-pin routing table of an interrupt controller and the small set of identification words around it. A processor reaches all of it through two bus offsets. One holds an 8-bit selector. The other is a data window that reads or writes whichever internal word the selector currently names. Each routing entry is 64 bits wide and is reached as two 32-bit halves. An even selector names the low half and an odd selector names the high half.

The whole table is exported as a flat vector to a separate delivery engine, which does the actual signalling. That engine reports accepted level-triggered deliveries back on a per-pin input, and the input sets the entry's remote-pending flag. Software clears the flag by rewriting the entry's low half. When software changes a pin's mask bit, the block emits a one-cycle notification carrying the pin and its new mask value.

Top module: `irq_route_regs`

## Requirements
- R1: The selector sits at bus offset 0x00. It is 8 bits wide, resets to 0, reads back in bits 7:0 with the upper bits 0, and changes only on a bus write to offset 0x00.
- R2: Only bits 7:0 of the bus address are decoded, and only offsets 0x00 and 0x10 (the window) respond. Reads at any other offset return 0. Writes at any other offset change no state.
- R3: With selector 0x01, the window reads NUM_PINS-1 in bits 23:16 and VERSION_CODE in bits 7:0, with all other bits 0. Window writes under this selector are ignored.
- R4: With selector 0x00, the window holds a 4-bit identifier in bits 27:24, with other bits reading 0. The identifier resets to 0. Selector 0x02 reads the same value, and window writes under selector 0x02 are discarded.
- R5: A selector s ≥ 0x10 names entry (s−0x10)>>1. An even s maps the window to bits 31:0 of that entry and an odd s maps it to bits 63:32. Entry p is exported on route_table[64p+63:64p].
- R6: A window access whose entry number is NUM_PINS or more reads 0, and a window write to it has no effect. Selectors 0x03 to 0x0F also read 0 through the window and ignore writes.
- R7: The entry layout is: vector 7:0, delivery mode 10:8, destination mode 11, spare 12, polarity 13, remote-pending 14, trigger mode 15 (1 = level), mask 16, reserved 55:17, destination ID 63:56. All fields except remote-pending store written data. Remote-pending is read-only from the bus.
- R8: A write to an entry's low half clears its remote-pending flag, and a high-half write leaves the flag unchanged. A high pend_set[p] sets the flag of pin p on the next clock edge. When pend_set[p] and a low-half write to p fall on the same edge, the flag ends at 1.
- R9: After reset every entry reads 0 except for the mask bit (bit 16), which reads 1.
- R10: A low-half write that changes an entry's mask bit makes mask_chg_valid high for exactly the following cycle, with mask_chg_pin equal to the entry number and mask_chg_value equal to the new mask. A write that leaves the mask unchanged, or that targets a high half, raises no notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Bus byte offset |
| bus_we | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational from address and state |
| pend_set | input | NUM_PINS | Per-pin remote-pending set request from the delivery engine |
| route_table | output | NUM_PINS*64 | All routing entries, pin 0 in the lowest 64 bits |
| mask_chg_valid | output | 1 | One-cycle mask-change notification |
| mask_chg_pin | output | PIN_IDX_W | Pin whose mask changed |
| mask_chg_value | output | 1 | New mask value |

## Verification
The two functions that collide are the delivery engine's pend_set request and a software low-half write to the same entry. The write clears remote-pending and the request sets it. The bench drives both in one cycle on a directed pin, and the random phase makes the same collision happen by chance. The result is judged by reading the low half back, which must show bit 14 set, and by the per-clock comparison of route_table against the behavioural model.

// File: rtl/irq_route_pkg.sv
// Package: shared layout of one routing entry and the selector decode kinds.
// Assumes 64-bit entries reached as two 32-bit halves.
package irq_route_pkg;

    localparam int ENTRY_W  = 64;
    localparam int HALF_W   = 32;
    localparam int MASK_BIT = 16;
    localparam int PEND_BIT = 14;
    localparam logic [7:0] SEL_ENTRY_BASE = 8'h10;

    // One routing entry, most significant field first.
    typedef struct packed {
        logic [7:0]  dest_id;
        logic [38:0] reserved;
        logic        mask;
        logic        level_trig;
        logic        remote_pend;
        logic        active_low;
        logic        spare;
        logic        logical_dest;
        logic [2:0]  deliv_mode;
        logic [7:0]  vector;
    } route_entry_t;

    // What the current selector points the window at.
    typedef enum logic [2:0] {
        SK_IDENT   = 3'd0,
        SK_VERSION = 3'd1,
        SK_ARBIT   = 3'd2,
        SK_ENTRY   = 3'd3,
        SK_NONE    = 3'd4
    } sel_kind_e;

endpackage

// File: rtl/irq_route_decode.sv
// Module: irq_route_decode
// Turns the 8-bit selector into a target kind, an entry number and a half.
// Assumes NUM_PINS is at most 120, so every valid entry number fits the selector.
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS  = 24,
    parameter int PIN_IDX_W = 5
) (
    input  logic [7:0]           sel,
    output sel_kind_e            kind,
    output logic [PIN_IDX_W-1:0] entry_idx,
    output logic                 hi_half
);

    logic [7:0] rel;
    logic [6:0] entry_num;

    // Offset from the first entry selector; bit 0 picks the half.
    always_comb begin
        rel       = sel - SEL_ENTRY_BASE;
        entry_num = rel[7:1];
        hi_half   = rel[0];
        entry_idx = PIN_IDX_W'(entry_num);
    end

    // Classify the selector.
    always_comb begin
        if (sel == 8'h00)
            kind = SK_IDENT;
        else if (sel == 8'h01)
            kind = SK_VERSION;
        else if (sel == 8'h02)
            kind = SK_ARBIT;
        else if (sel >= SEL_ENTRY_BASE && int'(entry_num) < NUM_PINS)
            kind = SK_ENTRY;
        else
            kind = SK_NONE;
    end

endmodule

// File: rtl/irq_route_entry.sv
// Module: irq_route_entry
// Storage for one 64-bit routing entry with a hardware-set remote-pending flag.
// Assumes wr_lo and wr_hi are never high together (one window access per cycle).
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    input  logic              pend_set,
    output logic [ENTRY_W-1:0] entry_o,
    output logic              mask_flip
);

    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;
    logic              pend_q;

    // Software-written halves; reset leaves only the mask set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= HALF_W'(1) << MASK_BIT;
            hi_q <= '0;
        end else begin
            if (wr_lo)
                lo_q <= wdata;
            if (wr_hi)
                hi_q <= wdata;
        end
    end

    // Remote-pending: the delivery engine's set wins over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (pend_set)
            pend_q <= 1'b1;
        else if (wr_lo)
            pend_q <= 1'b0;
    end

    // Assemble the entry with the pending flag in its own bit.
    always_comb begin
        entry_o   = {hi_q, lo_q[HALF_W-1:PEND_BIT+1], pend_q, lo_q[PEND_BIT-1:0]};
        mask_flip = wr_lo && (wdata[MASK_BIT] != lo_q[MASK_BIT]);
    end

    AST_PEND_CLEARED_BY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !pend_set) |=> !entry_o[PEND_BIT]); // R8

    AST_HIGH_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !pend_set) |=> (entry_o[PEND_BIT] == $past(entry_o[PEND_BIT]))); // R8

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pend_set |=> entry_o[PEND_BIT]); // R8

endmodule

// File: rtl/irq_route_regs.sv
// Module: irq_route_regs
// Selector/window register file for an interrupt routing table. It exports
// every entry and flags mask changes.
// Assumes single-cycle bus writes and combinational reads from address and state.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int         NUM_PINS     = 24,
    parameter logic [7:0] VERSION_CODE = 8'h11,
    parameter logic [7:0] SEL_OFS      = 8'h00,
    parameter logic [7:0] WIN_OFS      = 8'h10,
    localparam int        PIN_IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [7:0]                  bus_addr,
    input  logic                        bus_we,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [NUM_PINS-1:0]         pend_set,
    output logic [NUM_PINS*ENTRY_W-1:0] route_table,
    output logic                        mask_chg_valid,
    output logic [PIN_IDX_W-1:0]        mask_chg_pin,
    output logic                        mask_chg_value
);

    localparam logic [7:0] PIN_MAX = 8'(NUM_PINS - 1);

    logic [7:0]           sel_q;
    logic [3:0]           ident_q;
    sel_kind_e            kind;
    logic [PIN_IDX_W-1:0] dec_idx;
    logic                 dec_hi;
    logic                 win_wr;
    logic [NUM_PINS-1:0]  flip_vec;
    logic [ENTRY_W-1:0]   ent [NUM_PINS];
    logic [ENTRY_W-1:0]   sel_entry;
    logic [31:0]          win_rdata;
    logic                 chg_valid_q;
    logic [PIN_IDX_W-1:0] chg_pin_q;
    logic                 chg_value_q;

    irq_route_decode #(
        .NUM_PINS  (NUM_PINS),
        .PIN_IDX_W (PIN_IDX_W)
    ) u_decode (
        .sel       (sel_q),
        .kind      (kind),
        .entry_idx (dec_idx),
        .hi_half   (dec_hi)
    );

    // A window write is a bus write at the window offset.
    assign win_wr = bus_we && (bus_addr == WIN_OFS);

    // Selector register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_we && bus_addr == SEL_OFS)
            sel_q <= bus_wdata[7:0];
    end

    // Identifier register, written only through selector 0x00.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ident_q <= '0;
        else if (win_wr && kind == SK_IDENT)
            ident_q <= bus_wdata[27:24];
    end

    // One storage slice per pin.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic hit;
        assign hit = win_wr && (kind == SK_ENTRY) && (dec_idx == PIN_IDX_W'(p));

        irq_route_entry u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (hit && !dec_hi),
            .wr_hi     (hit && dec_hi),
            .wdata     (bus_wdata),
            .pend_set  (pend_set[p]),
            .entry_o   (ent[p]),
            .mask_flip (flip_vec[p])
        );

        assign route_table[p*ENTRY_W +: ENTRY_W] = ent[p];
    end

    // Mask-change notification, registered so it lines up with the new mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_valid_q <= 1'b0;
            chg_pin_q   <= '0;
            chg_value_q <= 1'b0;
        end else begin
            chg_valid_q <= |flip_vec;
            if (|flip_vec) begin
                chg_pin_q   <= dec_idx;
                chg_value_q <= bus_wdata[MASK_BIT];
            end
        end
    end

    assign mask_chg_valid = chg_valid_q;
    assign mask_chg_pin   = chg_pin_q;
    assign mask_chg_value = chg_value_q;

    // Window read mux over the selected target.
    always_comb begin
        sel_entry = ent[dec_idx];
        unique case (kind)
            SK_IDENT, SK_ARBIT: win_rdata = {4'h0, ident_q, 24'h0};
            SK_VERSION:         win_rdata = {8'h00, PIN_MAX, 8'h00, VERSION_CODE};
            SK_ENTRY:           win_rdata = dec_hi ? sel_entry[63:32] : sel_entry[31:0];
            default:            win_rdata = '0;
        endcase
    end

    // Bus read: selector, window, or zero.
    always_comb begin
        if (bus_addr == SEL_OFS)
            bus_rdata = {24'h0, sel_q};
        else if (bus_addr == WIN_OFS)
            bus_rdata = win_rdata;
        else
            bus_rdata = '0;
    end

    AST_SEL_ONLY_FROM_ITS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == SEL_OFS) |=> $stable(sel_q)); // R1

    AST_OTHER_OFFSETS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != SEL_OFS && bus_addr != WIN_OFS) |-> (bus_rdata == 32'h0)); // R2

    AST_IDENT_ONLY_FROM_SEL0: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_wr && sel_q == 8'h00) |=> $stable(ident_q)); // R4

    AST_OUT_OF_RANGE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && kind == SK_NONE && pend_set == '0) |=> $stable(route_table)); // R6

    AST_PULSE_MATCHES_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> (ent[mask_chg_pin][MASK_BIT] == mask_chg_value)); // R10

endmodule

// File: tb/test_irq_route_regs.sv
`timescale 1ns/1ps
module test_irq_route_regs;

    localparam int N   = 24;
    localparam int IW  = 5;
    localparam logic [7:0] VER = 8'h11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr = 8'h00;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = 32'h0;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    pend_set = '0;
    logic [N*64-1:0] route_table;
    logic            mask_chg_valid;
    logic [IW-1:0]   mask_chg_pin;
    logic            mask_chg_value;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Behavioural reference state
    logic [63:0] m_ent [N];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    bit          m_pulse;
    int          m_pin;
    bit          m_pval;
    bit          m_live = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    irq_route_regs #(.NUM_PINS(N), .VERSION_CODE(VER)) i_irq_route_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_set(pend_set),
        .route_table(route_table), .mask_chg_valid(mask_chg_valid),
        .mask_chg_pin(mask_chg_pin), .mask_chg_value(mask_chg_value)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int idx;
        if (a == 8'h00) return {24'h0, m_sel};
        if (a != 8'h10) return 32'h0;
        if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
        if (m_sel == 8'h01) return {8'h00, 8'(N-1), 8'h00, VER};
        if (m_sel < 8'h10) return 32'h0;
        idx = (int'(m_sel) - 16) / 2;
        if (idx >= N) return 32'h0;
        return m_sel[0] ? m_ent[idx][63:32] : m_ent[idx][31:0];
    endfunction

    // Reference model step and comparison, just after every rising edge
    always @(posedge clk) begin
        #0.5;
        if (!rst_n) begin
            for (int p = 0; p < N; p++) m_ent[p] = 64'h0000_0000_0001_0000; // R9
            m_sel = 8'h00; m_id = 4'h0; m_pulse = 0; m_pin = 0; m_pval = 0;
            m_live = 1'b1;
        end else begin
            m_pulse = 0;
            if (bus_we && bus_addr == 8'h00) m_sel = bus_wdata[7:0];
            else if (bus_we && bus_addr == 8'h10) begin
                if (m_sel == 8'h00) m_id = bus_wdata[27:24];
                else if (m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < N) begin
                    int idx;
                    idx = (int'(m_sel) - 16) / 2;
                    if (m_sel[0]) m_ent[idx][63:32] = bus_wdata;
                    else begin
                        if (m_ent[idx][16] != bus_wdata[16]) begin
                            m_pulse = 1; m_pin = idx; m_pval = bus_wdata[16];
                        end
                        m_ent[idx][31:0] = {bus_wdata[31:15], 1'b0, bus_wdata[13:0]};
                    end
                end
            end
            for (int p = 0; p < N; p++) if (pend_set[p]) m_ent[p][14] = 1'b1;
        end
        if (m_live) begin
            logic [N*64-1:0] flat;
            for (int p = 0; p < N; p++) flat[p*64 +: 64] = m_ent[p];
            check("R5 table", route_table == flat, 1);
            check("R10 pulse", mask_chg_valid, m_pulse);
            if (m_pulse) begin
                check("R10 pin", mask_chg_pin, m_pin);
                check("R10 value", mask_chg_value, m_pval);
            end
            check("R2 rdata", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); bus_addr = a; bus_we = 1'b0;
        #0.2; check(req, bus_rdata, exp);
    endtask

    task automatic pend(input int p);
        @(negedge clk); pend_set[p] = 1'b1;
        @(negedge clk); pend_set = '0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00, 32'h0, "R1 reset select");
        rd(8'h10, 32'h0, "R4 reset ident");
        wr(8'h00, 32'h10);
        rd(8'h10, 32'h0001_0000, "R9 reset low mask");
        wr(8'h00, 32'h11);
        rd(8'h10, 32'h0, "R9 reset high");
        // version
        wr(8'h00, 32'h01);
        rd(8'h10, {8'h00, 8'(N-1), 8'h00, VER}, "R3 version");
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, {8'h00, 8'(N-1), 8'h00, VER}, "R3 write ignored");
        // identifier
        wr(8'h00, 32'h00);
        wr(8'h10, 32'hA5FF_FFFF);
        rd(8'h10, 32'h0500_0000, "R4 ident");
        wr(8'h00, 32'h02);
        rd(8'h10, 32'h0500_0000, "R4 arb reads ident");
        wr(8'h10, 32'h0F00_0000);
        rd(8'h10, 32'h0500_0000, "R4 arb write discarded");
        // other offsets
        rd(8'h04, 32'h0, "R2 offset 04");
        rd(8'h20, 32'h0, "R2 offset 20");
        wr(8'h08, 32'hFF);
        rd(8'h00, 32'h02, "R2 stray write no effect");
        wr(8'h00, 32'hFFFF_FFAB);
        rd(8'h00, 32'h0000_00AB, "R1 select readback");
        // entry 3 low half, pending bit in data ignored, mask cleared
        wr(8'h00, 32'h16);
        wr(8'h10, 32'h0000_E142);
        check("R10 pulse after unmask", mask_chg_valid, 1);
        check("R10 pin", mask_chg_pin, 3);
        check("R10 value", mask_chg_value, 0);
        rd(8'h10, 32'h0000_A142, "R7 low layout, pending read-only");
        check("R10 single cycle", mask_chg_valid, 0);
        wr(8'h10, 32'h0000_A143);
        check("R10 no pulse same mask", mask_chg_valid, 0);
        wr(8'h00, 32'h17);
        wr(8'h10, 32'hC300_0001);
        check("R10 no pulse high half", mask_chg_valid, 0);
        check("R5 dest id export", route_table[3*64+56 +: 8], 8'hC3);
        // remote-pending
        pend(3);
        wr(8'h00, 32'h16);
        rd(8'h10, 32'h0000_E143, "R8 set by engine");
        wr(8'h00, 32'h17);
        wr(8'h10, 32'hC300_0002);
        wr(8'h00, 32'h16);
        rd(8'h10, 32'h0000_E143, "R8 high write keeps");
        wr(8'h10, 32'h0000_A143);
        rd(8'h10, 32'h0000_A143, "R8 low write clears");
        @(negedge clk); bus_addr = 8'h10; bus_we = 1'b1; bus_wdata = 32'h0001_A143; pend_set[3] = 1'b1;
        @(negedge clk); bus_we = 1'b0; pend_set = '0;
        check("R10 remask pulse", mask_chg_value, 1);
        rd(8'h10, 32'h0001_E143, "R8 set wins over clear");
        // last pin and out-of-range
        wr(8'h00, 32'h3F);
        wr(8'h10, 32'h7700_0000);
        check("R5 last pin", route_table[23*64+56 +: 8], 8'h77);
        wr(8'h00, 32'h40);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R6 out of range reads 0");
        wr(8'h00, 32'h05);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R6 reserved selector");
        // random traffic against the model
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom % 5);
            @(negedge clk);
            bus_we = 1'b0; pend_set = '0;
            case (op)
                0: begin bus_addr = 8'h00; bus_we = 1'b1; bus_wdata = $urandom % 32'h48; end
                1, 2: begin bus_addr = 8'h10; bus_we = 1'b1; bus_wdata = $urandom; end
                3: begin pend_set[$urandom % N] = 1'b1; bus_addr = 8'h10; bus_we = 1'b1; bus_wdata = $urandom; end
                default: bus_addr = 8'($urandom);
            endcase
        end
        @(negedge clk); bus_we = 1'b0; pend_set = '0;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule